// File: doc/BRIEF.md
# CPU Program Counter and Status Word Unit

This block keeps the sequencing state of a small 8-bit processor core. It owns a 16-bit program counter and an 8-bit status word. Around them, decode, arithmetic, interrupt arbitration, the stack and the register file all sit outside the block. Those neighbours send one-cycle requests, and the block applies them on the next clock edge. A request can step the counter by the length of the instruction just fetched, or load a branch target. It can also acknowledge an interrupt, enable or disable interrupts, or update flags from an arithmetic result. Finally, it can overwrite the status word with a byte popped from the stack.

When reset is released, the block reads the start address through its synchronous memory read port. It reads the low byte from address 0000H and then the high byte from 0001H, in consecutive cycles. It raises `ready_o` once the counter holds that address. Until then, every control request is ignored. The counter and the status word are always present on the outputs, so the stack logic can save them whenever it needs to. The register-bank select pair and the interrupt-enable state are also brought out as separate outputs for convenience.

Top module: `cpu_seq_regs`

## Requirements
- R1: While reset is held and in the first cycle after it, `psw_o` is 02H, `pc_o` is 0000H, `ready_o` is 0 and `int_en_o` is 0.
- R2: After reset, the block asserts `mem_rd_o` with `mem_addr_o` = 0000H, then with 0001H in the next cycle. It loads `pc_o` = {byte at 0001H, byte at 0000H} and raises `ready_o` on the third clock edge after reset is released. `ready_o` then stays high and `mem_rd_o` stays low. Control requests made before `ready_o` is high have no effect.
- R3: With `adv_i` high and `br_i` low, the counter grows by `adv_len_i` (1 to 4), modulo 2^16.
- R4: With `br_i` high, the counter takes the value of `br_tgt_i`. This holds even if `adv_i` is also high.
- R5: Interrupt enable is status bit 7. `di_i` or `irq_ack_i` clears it, and `ei_i` sets it. When `irq_ack_i` and `ei_i` arrive together, the bit ends at 0.
- R6: With `z_en_i` high, status bit 6 (Z) becomes 1 if `alu_res_i` is zero and 0 otherwise. With `z_en_i` low, Z is unchanged.
- R7: Carry (bit 0) loads `cy_i` only when `cy_en_i` is high. Auxiliary carry (bit 4) loads `ac_i` only when `ac_en_i` is high. Each flag is otherwise unchanged.
- R8: `psw_ld_i` replaces the whole status word with `psw_val_i`, except that bit 2 is forced to 0. In the same cycle it takes priority over the flag, EI, DI and acknowledge requests.
- R9: `bank_o` is {bit 5, bit 3} of the status word, and `int_en_o` equals bit 7. Bit 1 is the in-service priority flag and changes only by `psw_ld_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd_o | output | 1 | Read strobe for vector fetch |
| mem_addr_o | output | 16 | Read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after strobe |
| ready_o | output | 1 | Counter holds the start address |
| adv_i | input | 1 | Sequential advance request |
| adv_len_i | input | 3 | Instruction length in bytes, 1 to 4 |
| br_i | input | 1 | Branch load request |
| br_tgt_i | input | 16 | Branch target |
| irq_ack_i | input | 1 | Interrupt acknowledged |
| ei_i | input | 1 | Enable-interrupts operation |
| di_i | input | 1 | Disable-interrupts operation |
| z_en_i | input | 1 | Update zero flag |
| alu_res_i | input | 8 | Result tested for zero |
| cy_en_i | input | 1 | Update carry |
| cy_i | input | 1 | New carry |
| ac_en_i | input | 1 | Update auxiliary carry |
| ac_i | input | 1 | New auxiliary carry |
| psw_ld_i | input | 1 | Restore status word |
| psw_val_i | input | 8 | Restored status byte |
| pc_o | output | 16 | Program counter |
| psw_o | output | 8 | Status word |
| bank_o | output | 2 | Register bank select |
| int_en_o | output | 1 | Interrupt enable state |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit result and a vector base of 0000H. These values make the two-byte vector fetch and the wrap of the counter at FFFFH reachable. With a 3-bit length field, all four legal instruction lengths can be applied, including lengths that carry into the high byte. With an 8-bit result, the zero test can be exercised at both its all-zero and single-bit-set edges.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;
   localparam int PSW_W   = 8;
   localparam int B_IE    = 7;
   localparam int B_Z     = 6;
   localparam int B_RB1   = 5;
   localparam int B_AC    = 4;
   localparam int B_RB0   = 3;
   localparam int B_ZERO  = 2;
   localparam int B_ISP   = 1;
   localparam int B_CY    = 0;
   localparam logic [PSW_W-1:0] PSW_INIT = 8'h02;
endpackage

// File: rtl/cpu_seq_vecload.sv
module cpu_seq_vecload #(
   parameter int ADDR_W   = 16,
   parameter int VEC_BASE = 0,
   localparam int NB      = ADDR_W / 8,
   localparam int CNT_W   = $clog2(NB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_o,
   output logic [ADDR_W-1:0] addr_o,
   input  logic [7:0]        rdata_i,
   output logic              load_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic              ready_o
);
   logic [CNT_W-1:0] issue_q;
   logic             pend_q;
   logic [CNT_W-1:0] pidx_q;

   assign rd_o   = !ready_o && (issue_q < CNT_W'(NB));
   assign addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(issue_q);
   assign load_o = pend_q && (pidx_q == CNT_W'(NB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_q <= '0;
         pend_q  <= 1'b0;
         pidx_q  <= '0;
         ready_o <= 1'b0;
      end else begin
         pend_q <= rd_o;
         if (rd_o) begin
            issue_q <= issue_q + 1'b1;
            pidx_q  <= issue_q;
         end
         if (load_o) ready_o <= 1'b1;
      end
   end

   for (genvar i = 0; i < NB; i++) begin : g_lane
      if (i == NB - 1) begin : g_top
         assign vec_o[8*i +: 8] = rdata_i;
      end else begin : g_low
         logic [7:0] b_q;
         always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else if (pend_q && pidx_q == CNT_W'(i)) b_q <= rdata_i;
         end
         assign vec_o[8*i +: 8] = b_q;
      end
   end

   p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o);
   p_no_read_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !rd_o);
endmodule

// File: rtl/cpu_seq_pc.sv
module cpu_seq_pc #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              vec_ld_i,
   input  logic [ADDR_W-1:0] vec_i,
   input  logic              adv_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              br_i,
   input  logic [ADDR_W-1:0] tgt_i,
   output logic [ADDR_W-1:0] pc_o
);
   logic [ADDR_W-1:0] nxt;

   always_comb begin
      nxt = pc_o;
      if (vec_ld_i)             nxt = vec_i;
      else if (go_i && br_i)    nxt = tgt_i;
      else if (go_i && adv_i)   nxt = pc_o + ADDR_W'(len_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_o <= '0;
      else        pc_o <= nxt;
   end

   p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && br_i && !vec_ld_i) |=> pc_o == $past(tgt_i));
   p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && adv_i && !br_i && !vec_ld_i) |=> pc_o == $past(pc_o) + ADDR_W'($past(len_i)));
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_i && !vec_ld_i) |=> $stable(pc_o));
endmodule

// File: rtl/cpu_seq_psw.sv
module cpu_seq_psw
   import cpu_seq_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             ack_i,
   input  logic             ei_i,
   input  logic             di_i,
   input  logic             z_en_i,
   input  logic [RES_W-1:0] res_i,
   input  logic             cy_en_i,
   input  logic             cy_i,
   input  logic             ac_en_i,
   input  logic             ac_i,
   input  logic             ld_i,
   input  logic [PSW_W-1:0] val_i,
   output logic [PSW_W-1:0] psw_o
);
   localparam logic [PSW_W-1:0] LD_MASK = ~(PSW_W'(1) << B_ZERO);
   logic [PSW_W-1:0] nxt;

   always_comb begin
      nxt = psw_o;
      if (go_i) begin
         if (ld_i) begin
            nxt = val_i & LD_MASK;
         end else begin
            if (z_en_i)  nxt[B_Z]  = ~|res_i;
            if (cy_en_i) nxt[B_CY] = cy_i;
            if (ac_en_i) nxt[B_AC] = ac_i;
            if (ack_i || di_i) nxt[B_IE] = 1'b0;
            else if (ei_i)     nxt[B_IE] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) psw_o <= PSW_INIT;
      else        psw_o <= nxt;
   end

   p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && ld_i) |=> psw_o == ($past(val_i) & LD_MASK));
   p_ack_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && ack_i && !ld_i) |=> !psw_o[B_IE]);
   p_ei_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && ei_i && !ack_i && !di_i && !ld_i) |=> psw_o[B_IE]);
   p_cy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_i && (cy_en_i || ld_i)) |=> $stable(psw_o[B_CY]));
   p_ac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_i && (ac_en_i || ld_i)) |=> $stable(psw_o[B_AC]));
   p_zero_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !psw_o[B_ZERO]);
endmodule

// File: rtl/cpu_seq_regs.sv
module cpu_seq_regs
   import cpu_seq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LEN_W    = 3,
   parameter int RES_W    = 8,
   parameter int VEC_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [7:0]        mem_rdata_i,
   output logic              ready_o,
   input  logic              adv_i,
   input  logic [LEN_W-1:0]  adv_len_i,
   input  logic              br_i,
   input  logic [ADDR_W-1:0] br_tgt_i,
   input  logic              irq_ack_i,
   input  logic              ei_i,
   input  logic              di_i,
   input  logic              z_en_i,
   input  logic [RES_W-1:0]  alu_res_i,
   input  logic              cy_en_i,
   input  logic              cy_i,
   input  logic              ac_en_i,
   input  logic              ac_i,
   input  logic              psw_ld_i,
   input  logic [PSW_W-1:0]  psw_val_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [PSW_W-1:0]  psw_o,
   output logic [1:0]        bank_o,
   output logic              int_en_o
);
   if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must be a multiple of 8 and at least 16");
   end
   if (LEN_W < 3) begin : g_bad_len
      $error("LEN_W must hold lengths up to 4");
   end
   if (RES_W < 1) begin : g_bad_res
      $error("RES_W must be positive");
   end

   logic              vec_ld;
   logic [ADDR_W-1:0] vec;

   cpu_seq_vecload #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
      .clk(clk), .rst_n(rst_n), .rd_o(mem_rd_o), .addr_o(mem_addr_o),
      .rdata_i(mem_rdata_i), .load_o(vec_ld), .vec_o(vec), .ready_o(ready_o)
   );

   cpu_seq_pc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pc (
      .clk(clk), .rst_n(rst_n), .go_i(ready_o), .vec_ld_i(vec_ld), .vec_i(vec),
      .adv_i(adv_i), .len_i(adv_len_i), .br_i(br_i), .tgt_i(br_tgt_i), .pc_o(pc_o)
   );

   cpu_seq_psw #(.RES_W(RES_W)) u_psw (
      .clk(clk), .rst_n(rst_n), .go_i(ready_o), .ack_i(irq_ack_i), .ei_i(ei_i),
      .di_i(di_i), .z_en_i(z_en_i), .res_i(alu_res_i), .cy_en_i(cy_en_i),
      .cy_i(cy_i), .ac_en_i(ac_en_i), .ac_i(ac_i), .ld_i(psw_ld_i),
      .val_i(psw_val_i), .psw_o(psw_o)
   );

   assign bank_o   = {psw_o[B_RB1], psw_o[B_RB0]};
   assign int_en_o = psw_o[B_IE];

   p_isp_only_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready_o && psw_ld_i) |=> $stable(psw_o[B_ISP]));
endmodule

// File: tb/cpu_seq_regs_bench.sv
module cpu_seq_regs_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        mem_rd, ready, int_en;
   logic [15:0] mem_addr, pc;
   logic [7:0]  mem_rdata, psw;
   logic [1:0]  bank;
   logic        adv = 0, br = 0, ack = 0, ei = 0, di = 0;
   logic [2:0]  alen = 0;
   logic [15:0] tgt = 0;
   logic        zen = 0, cyen = 0, cyv = 0, acen = 0, acv = 0, pld = 0;
   logic [7:0]  res = 0, pval = 0;

   cpu_seq_regs u_cpu_seq_regs (
      .clk(clk), .rst_n(rst_n), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
      .mem_rdata_i(mem_rdata), .ready_o(ready), .adv_i(adv), .adv_len_i(alen),
      .br_i(br), .br_tgt_i(tgt), .irq_ack_i(ack), .ei_i(ei), .di_i(di),
      .z_en_i(zen), .alu_res_i(res), .cy_en_i(cyen), .cy_i(cyv),
      .ac_en_i(acen), .ac_i(acv), .psw_ld_i(pld), .psw_val_i(pval),
      .pc_o(pc), .psw_o(psw), .bank_o(bank), .int_en_o(int_en)
   );

   always_ff @(posedge clk)
      if (mem_rd)
         mem_rdata <= (mem_addr == 16'h0000) ? 8'h34 :
                      (mem_addr == 16'h0001) ? 8'h12 : 8'hEE;

   int tests = 0, fails = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard
   logic [15:0] e_pc;
   logic [7:0]  e_psw;
   logic [15:0] q_pc[$];
   logic [7:0]  q_psw[$];
   string       q_tag[$];
   event        mon_ev;

   initial forever begin
      @(mon_ev);
      while (q_pc.size() > 0) begin
         automatic logic [15:0] xp = q_pc.pop_front();
         automatic logic [7:0]  xs = q_psw.pop_front();
         automatic string       t  = q_tag.pop_front();
         chk({t, " pc"}, 32'(pc), 32'(xp));
         chk({t, " psw"}, 32'(psw), 32'(xs));
         chk({t, " bank R9"}, 32'(bank), 32'({xs[5], xs[3]}));
         chk({t, " int_en R9"}, 32'(int_en), 32'(xs[7]));
      end
   end

   task automatic apply(input string tag);
      @(posedge clk);
      if (pld) e_psw = pval & 8'hFB;
      else begin
         if (zen)  e_psw[6] = (res == 8'h00);
         if (cyen) e_psw[0] = cyv;
         if (acen) e_psw[4] = acv;
         if (ack || di) e_psw[7] = 1'b0;
         else if (ei)   e_psw[7] = 1'b1;
      end
      if (br)       e_pc = tgt;
      else if (adv) e_pc = e_pc + 16'(alen);
      q_pc.push_back(e_pc);
      q_psw.push_back(e_psw);
      q_tag.push_back(tag);
      @(negedge clk);
      adv = 0; br = 0; ack = 0; ei = 0; di = 0; zen = 0; cyen = 0;
      acen = 0; pld = 0;
      ->mon_ev;
      #1;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 psw in reset", 32'(psw), 32'h02);
      chk("R1 ready in reset", 32'(ready), 0);
      rst_n = 1'b1;
      // requests during vector fetch must be ignored
      adv = 1; alen = 3'd2; br = 1; tgt = 16'hBEEF; ei = 1; pld = 1; pval = 8'hFF;
      #1;
      chk("R1 pc after release", 32'(pc), 0);
      chk("R1 int_en after release", 32'(int_en), 0);
      chk("R2 first read strobe", 32'(mem_rd), 1);
      chk("R2 first read addr", 32'(mem_addr), 16'h0000);
      @(negedge clk);
      chk("R2 second read strobe", 32'(mem_rd), 1);
      chk("R2 second read addr", 32'(mem_addr), 16'h0001);
      chk("R2 not ready yet", 32'(ready), 0);
      @(negedge clk);
      chk("R2 no third read", 32'(mem_rd), 0);
      chk("R2 not ready before load", 32'(ready), 0);
      adv = 0; br = 0; ei = 0; pld = 0;
      @(negedge clk);
      chk("R2 ready raised", 32'(ready), 1);
      chk("R2 pc loaded from vector", 32'(pc), 16'h1234);
      chk("R2 psw untouched while loading", 32'(psw), 8'h02);
      e_pc = 16'h1234; e_psw = 8'h02;

      for (int l = 1; l <= 4; l++) begin
         adv = 1; alen = 3'(l); apply("R3 advance");
      end
      br = 1; adv = 1; alen = 3'd3; tgt = 16'hFFFE; apply("R4 branch beats advance");
      adv = 1; alen = 3'd4; apply("R3 wrap past FFFF");
      ei = 1; apply("R5 EI sets IE");
      di = 1; apply("R5 DI clears IE");
      ei = 1; apply("R5 EI again");
      ack = 1; ei = 1; apply("R5 ack beats EI");
      zen = 1; res = 8'h00; apply("R6 zero result");
      zen = 1; res = 8'h80; apply("R6 nonzero result");
      zen = 1; res = 8'h00; apply("R6 zero again");
      res = 8'h55; cyv = 1; acv = 1; apply("R6 R7 no enables hold");
      cyen = 1; cyv = 1; acv = 1; apply("R7 carry only");
      acen = 1; acv = 1; cyv = 0; apply("R7 aux carry only");
      pld = 1; pval = 8'hFF; ei = 1; zen = 1; res = 8'h01; cyen = 1; cyv = 0;
      apply("R8 restore bit2 forced, priority");
      pld = 1; pval = 8'h28; apply("R9 bank select");
      pld = 1; pval = 8'h80; apply("R8 restore IE only");
      ack = 1; apply("R5 ack clears IE");
      br = 1; tgt = 16'h00FF; apply("R4 branch");
      adv = 1; alen = 3'd1; apply("R3 carry into high byte");

      @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule